// File: doc/BRIEF.md
# Debug Halt, Step and Core-Register Access Controller

This block sits next to a small processor core and gives an external debugger control over execution. Through a 32-bit word-addressed register port the debugger can stop the core, let it run again, advance it by a single instruction, and move values between a bus-visible data word and any register inside the core. A separate catch register makes the core stop before it executes anything after a core reset, so that a debug session can begin from a known point.

Four words are visible on the port: a control/status word at address 0, a transfer selector at address 1, a transfer data word at address 2 and a catch word at address 3. All debug state is cleared only by the power-on reset input. The core reset input never disturbs it, so a session survives repeated core resets. On the core side the block drives a level halt request and a one-cycle step request, and it receives the halted level and a one-cycle retired pulse. On the register-file side it issues a request that is held until the core side acknowledges it.

Top module: `dbg_halt_ctl`

## Requirements
- R1: When `por_n` is low, every stored field clears. Afterwards address 0 reads 0x0001_0000 (only the ready flag is set), addresses 1, 2 and 3 read 0, and `core_halt_req` and `rf_req` are low.
- R2: Holding `core_rst_n` low changes none of the stored fields. The only effect it can have is the halt-bit set described in R9.
- R3: A write to address 0 is accepted only when `bus_wdata[31:16]` equals 0xA05F. A write without the key leaves every control bit unchanged.
- R4: Control bit 0 is debug-enable and bit 1 is halt. `core_halt_req` is high exactly when both stored bits are set. It goes high in the cycle after an accepted write sets them and low in the cycle after an accepted write clears one of them.
- R5: An accepted address-0 write sets bit 2 (step). If that same write also sets bits 0 and 1, and `core_halted` is high, and no earlier step is still pending, `core_step_req` pulses for exactly one cycle in the cycle after the write. Otherwise there is no pulse. The step bit always reads back as 0.
- R6: A write to address 1 starts a transfer when debug is enabled, `core_halted` is high and the ready flag is set. In the next cycle `rf_req` is high, `rf_sel` carries `bus_wdata[6:0]`, `rf_we` carries `bus_wdata[16]` (1 = write the core register, 0 = read it) and the ready flag is clear. The request holds steady until `rf_ack`.
- R7: On a read transfer, the `rf_rdata` value present with `rf_ack` is stored in the data word. On a write transfer, `rf_wdata` carries the data word. In both cases the ready flag is set again in the cycle after `rf_ack`. A write to address 2 while a transfer is open is ignored.
- R8: A selector write while the core is not halted, or while a transfer is open, is ignored. No request is issued, and the selector word and the ready flag keep their values.
- R9: If catch bit 0 and debug-enable are both set while `core_rst_n` is low, the halt bit is set. `core_halt_req` is therefore already high when the core leaves reset. If debug-enable is clear, a core reset leaves the halt request low.
- R10: `bus_rdata` is registered and shows the word addressed at the previous clock edge. The status word has the halted input at bit 17, the ready flag at bit 16 and the control bits at 2:0. The selector word has the direction bit at bit 16 and the select field at 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| core_rst_n | input | 1 | Core reset level, active low |
| bus_addr | input | 2 | Word address of the register port |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_halt_req | output | 1 | Level request to stop the core |
| core_step_req | output | 1 | One-cycle request to run one instruction |
| core_halted | input | 1 | Core reports it is stopped |
| core_retired | input | 1 | One-cycle pulse when an instruction completes |
| rf_req | output | 1 | Core-register transfer request |
| rf_we | output | 1 | Transfer direction, 1 = write the core register |
| rf_sel | output | 7 | Selected core register |
| rf_wdata | output | 32 | Value to write into the core register |
| rf_rdata | input | 32 | Value read from the core register |
| rf_ack | input | 1 | Transfer completion |

## Verification
The bench targets the ways this controller can leak control to the wrong party. It writes the control word without the key and checks that nothing changed. A design that ignored the key would raise the halt request there. It also sets halt without debug-enable, where a design that skipped the enable gate would stop the core. Stepping is tried both with and without the halt bit in the same write, and with the core running. A design that latched the step bit, or skipped the halt condition, would let the core run extra instructions or step it while it was free-running. Transfers are attempted while the core is running, and the test relies on a core reset neither wiping the selector and catch words nor losing the catch. A design that reset its registers on the core reset, or ignored the catch, would let the core run off before the debugger could stop it.

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl #(
  parameter int          SELW = 7,
  parameter logic [15:0] KEY  = 16'hA05F
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            core_rst_n,
  input  logic [1:0]      bus_addr,
  input  logic            bus_we,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            core_halt_req,
  output logic            core_step_req,
  input  logic            core_halted,
  input  logic            core_retired,
  output logic            rf_req,
  output logic            rf_we,
  output logic [SELW-1:0] rf_sel,
  output logic [31:0]     rf_wdata,
  input  logic [31:0]     rf_rdata,
  input  logic            rf_ack
);

  localparam int PADW = 16 - SELW;

  logic            dbg_en, halt_bit, step_q, step_busy, catch_q;
  logic            ready, req_q, dir_q;
  logic [SELW-1:0] sel_q;
  logic [31:0]     data_q;

  wire ctrl_wr = bus_we && bus_addr == 2'd0 && bus_wdata[31:16] == KEY;
  wire sel_wr  = bus_we && bus_addr == 2'd1;
  wire data_wr = bus_we && bus_addr == 2'd2;
  wire cat_wr  = bus_we && bus_addr == 2'd3;
  wire step_ok = bus_wdata[0] && bus_wdata[1] && bus_wdata[2] && core_halted && !step_busy;
  wire xfer_ok = sel_wr && ready && core_halted && dbg_en;

  assign core_halt_req = dbg_en & halt_bit;
  assign core_step_req = step_q;
  assign rf_req        = req_q;
  assign rf_we         = dir_q;
  assign rf_sel        = sel_q;
  assign rf_wdata      = data_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dbg_en    <= 1'b0;
      halt_bit  <= 1'b0;
      step_q    <= 1'b0;
      step_busy <= 1'b0;
      catch_q   <= 1'b0;
    end else begin
      step_q <= 1'b0;
      if (core_retired) step_busy <= 1'b0;
      if (ctrl_wr) begin
        dbg_en   <= bus_wdata[0];
        halt_bit <= bus_wdata[1];
        if (step_ok) begin
          step_q    <= 1'b1;
          step_busy <= 1'b1;
        end
      end
      if (cat_wr) catch_q <= bus_wdata[0];
      if (!core_rst_n && catch_q && dbg_en) halt_bit <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ready  <= 1'b1;
      req_q  <= 1'b0;
      dir_q  <= 1'b0;
      sel_q  <= '0;
      data_q <= '0;
    end else if (req_q) begin
      if (rf_ack) begin
        req_q <= 1'b0;
        ready <= 1'b1;
        if (!dir_q) data_q <= rf_rdata;
      end
    end else begin
      if (data_wr) data_q <= bus_wdata;
      if (xfer_ok) begin
        sel_q <= bus_wdata[SELW-1:0];
        dir_q <= bus_wdata[16];
        req_q <= 1'b1;
        ready <= 1'b0;
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    case (bus_addr)
      2'd0:    rd_mux = {14'd0, core_halted, ready, 13'd0, 1'b0, halt_bit, dbg_en};
      2'd1:    rd_mux = {15'd0, dir_q, {PADW{1'b0}}, sel_q};
      2'd2:    rd_mux = data_q;
      default: rd_mux = {31'd0, catch_q};
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end

  a_r5_step_needs_halt: assert property (@(posedge clk) disable iff (!por_n)
    core_step_req |-> core_halt_req);
  a_r5_step_single: assert property (@(posedge clk) disable iff (!por_n)
    core_step_req |=> !core_step_req);
  a_r6_req_steady: assert property (@(posedge clk) disable iff (!por_n)
    rf_req && !rf_ack |=> rf_req && $stable(rf_sel) && $stable(rf_we));
  a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!por_n)
    rf_req |-> !ready);
  a_r3_no_key_no_change: assert property (@(posedge clk) disable iff (!por_n)
    bus_we && bus_addr == 2'd0 && bus_wdata[31:16] != KEY && core_rst_n
    |=> $stable(dbg_en) && $stable(halt_bit));
  a_r9_catch_holds: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst_n) && catch_q && dbg_en |-> core_halt_req);

endmodule

// File: tb/dbg_halt_ctl_tb.sv
module dbg_halt_ctl_tb_top;
  localparam int CLK_NS = 10;

  logic clk = 0, por_n = 0, core_rst_n = 1;
  logic [1:0] bus_addr = 0;
  logic bus_we = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic core_halt_req, core_step_req, rf_req, rf_we;
  logic core_halted = 0, core_retired = 0, rf_ack = 0, m_busy = 0;
  logic [6:0] rf_sel;
  logic [31:0] rf_wdata, rf_rdata;
  int total = 0, bad = 0, steps = 0, rets = 0;
  logic [6:0] last_wsel = 0;
  logic [31:0] last_wdat = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_NS/2) clk = ~clk;

  dbg_halt_ctl dut_i (.*);

  assign rf_rdata = 32'hC0DE_0000 | {25'd0, rf_sel};

  always @(posedge clk) begin
    if (!core_rst_n) begin
      core_halted <= 0; m_busy <= 0; core_retired <= 0;
    end else if (core_step_req && core_halted) begin
      core_halted <= 0; m_busy <= 1; core_retired <= 0;
    end else if (m_busy) begin
      m_busy <= 0; core_retired <= 1; core_halted <= 1;
    end else begin
      core_retired <= 0; core_halted <= core_halt_req;
    end
    rf_ack <= rf_req && !rf_ack;
    if (rf_req && rf_ack && rf_we) begin last_wsel <= rf_sel; last_wdat <= rf_wdata; end
    if (core_step_req) steps <= steps + 1;
    if (core_retired) rets <= rets + 1;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    bus_addr = a;
    @(posedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 100000);
    bad++; total++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3); por_n = 1; idle(1);
    chk(core_halt_req, 0, "R1 halt_req");
    chk(rf_req, 0, "R1 rf_req");
    rd(0, 32'h0001_0000, "R1 status");
    rd(1, 0, "R1 sel"); rd(2, 0, "R1 data"); rd(3, 0, "R1 catch");

    wr(0, 32'h1234_0003); idle(2);
    chk(core_halt_req, 0, "R3 no key halt_req");
    rd(0, 32'h0001_0000, "R3 no key status");

    wr(0, {16'hA05F, 16'h0002}); idle(2);
    chk(core_halt_req, 0, "R4 halt without enable");
    rd(0, 32'h0001_0002, "R4 status halt bit only");

    wr(0, {16'hA05F, 16'h0003});
    chk(core_halt_req, 1, "R4 halt_req next cycle");
    idle(2);
    rd(0, 32'h0003_0003, "R10 status halted");

    wr(1, 32'h0000_0005);
    chk(rf_req, 1, "R6 rf_req"); chk(rf_sel, 5, "R6 rf_sel"); chk(rf_we, 0, "R6 rf_we");
    rd(0, 32'h0002_0003, "R6 ready clear");
    idle(3);
    rd(0, 32'h0003_0003, "R7 ready set");
    rd(2, 32'hC0DE_0005, "R7 read data");

    wr(2, 32'h1234_5678);
    wr(1, 32'h0001_0009);
    chk(rf_we, 1, "R6 write dir");
    wr(2, 32'hDEAD_BEEF);
    idle(4);
    chk(last_wsel, 9, "R7 write sel");
    chk(last_wdat, 32'h1234_5678, "R7 write data");
    rd(2, 32'h1234_5678, "R7 data write while busy ignored");
    rd(1, 32'h0001_0009, "R10 sel layout");

    steps = 0; rets = 0;
    wr(0, {16'hA05F, 16'h0007});
    chk(core_step_req, 1, "R5 step pulse");
    idle(5);
    chk(steps, 1, "R5 one step");
    chk(rets, 1, "R5 one retire");
    rd(0, 32'h0003_0003, "R5 halted again, step reads 0");

    wr(0, {16'hA05F, 16'h0001}); idle(2);
    chk(core_halt_req, 0, "R4 resume");
    steps = 0;
    wr(0, {16'hA05F, 16'h0005}); idle(3);
    chk(steps, 0, "R5 no step without halt");

    wr(1, 32'h0000_0011); idle(1);
    chk(rf_req, 0, "R8 no request while running");
    rd(1, 32'h0001_0009, "R8 sel unchanged");
    rd(0, 32'h0001_0001, "R8 ready unchanged");

    wr(3, 1);
    core_rst_n = 0; idle(3);
    rd(3, 1, "R2 catch survives core reset");
    rd(1, 32'h0001_0009, "R2 sel survives core reset");
    core_rst_n = 1;
    chk(core_halt_req, 1, "R9 halt at reset exit");
    idle(3);
    rd(0, 32'h0003_0003, "R9 status after catch");

    wr(0, {16'hA05F, 16'h0000});
    core_rst_n = 0; idle(3); core_rst_n = 1; idle(2);
    chk(core_halt_req, 0, "R9 no catch without enable");

    por_n = 0; idle(2); por_n = 1; idle(1);
    rd(3, 0, "R1 catch cleared by por");
    rd(0, 32'h0001_0000, "R1 status after por");
    idle(2);
    finish_run();
  end
endmodule